// File: doc/BRIEF.md
# Exception Priority Mask Filter

This block sits between an exception arbiter and the core's entry sequencer. The arbiter presents a single pending exception: its type number and its priority value, where a smaller value is more urgent. The block decides whether that exception may be taken now. Three mask registers drive the decision:

- a one-bit global mask;
- a one-bit fault mask;
- a priority threshold `PRIO_W` bits wide.

Each mask exempts a different set of exception types. The non-maskable interrupt (type 2) always passes. The hard fault (type 3) is stopped only by the fault mask. Every other type is subject to all three masks.

Software reads and writes the masks through a small select/data port. Writes are accepted only from privileged code. A write made at user level changes nothing and raises a one-cycle access-fault pulse. The allow decision is registered: it reflects the pending inputs and the mask values as they stood at the clock edge that captured it.

Top module: `exc_mask_filter`

## Requirements
- R1: After reset, all three mask registers read as zero, and `take_ok` and `acc_fault` are 0.
- R2: A pending exception of type 2 gives `take_ok`=1 one cycle later, whatever the mask settings.
- R3: With the global mask set (bit 0 of the value written to select 0), every pending type other than 2 and 3 is denied. Types 2 and 3 are unaffected by this mask.
- R4: With the fault mask set (bit 0 of the value written to select 1), every pending type other than 2 is denied, type 3 included.
- R5: With a nonzero threshold (select 2), a pending type other than 2 and 3 is denied when its priority value is equal to or greater than the threshold. It is allowed when its priority value is below the threshold and no other mask blocks it. Type 3 ignores the threshold.
- R6: A threshold of zero applies no priority masking, so even priority value all-ones is allowed.
- R7: A privileged write (`priv`=1, `wr_en`=1) updates the selected register at the clock edge. `rd_data` shows the value for `rd_sel` combinationally: selects 0 and 1 read the mask bit in bit 0 with the other bits zero, and select 2 reads the threshold.
- R8: A write with `priv`=0 leaves all three registers unchanged. It sets `acc_fault` for exactly the following cycle.
- R9: `take_ok` is registered. After an edge, it equals `pend_valid` AND the mask decision, using the register values from before that edge. With `pend_valid`=0 it is 0.
- R10: Select 3 is reserved. A privileged write to it changes no register and raises no fault, and it reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pend_valid | input | 1 | A pending exception is presented |
| pend_type | input | TYPE_W | Exception type number of the pending exception |
| pend_prio | input | PRIO_W | Priority value of the pending exception (smaller is more urgent) |
| priv | input | 1 | 1 = privileged access level, 0 = user level |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 2 | Write select: 0 global mask, 1 fault mask, 2 threshold, 3 reserved |
| wr_data | input | PRIO_W | Write data |
| rd_sel | input | 2 | Read select, same encoding as `wr_sel` |
| rd_data | output | PRIO_W | Read data for `rd_sel` |
| take_ok | output | 1 | Registered permission to take the pending exception |
| acc_fault | output | 1 | One-cycle pulse after a refused user-level write |

## Verification
The assertions assume a well-formed pending input. `pend_type` and `pend_prio` are stable and meaningful whenever `pend_valid` is high. They also assume that `priv` describes the same cycle as the write it qualifies.

The stimulus changes inputs only on the falling clock edge. Registers are programmed in separate cycles before each vector is presented. It overlaps a write with a pending exception only in the one directed case that checks which register value the decision uses.

// File: rtl/exc_mask_pkg.sv
package exc_mask_pkg;
  localparam int unsigned NMI_TYPE  = 2;
  localparam int unsigned HARD_TYPE = 3;

  typedef enum logic [1:0] {
    SEL_GMASK = 2'd0,
    SEL_FMASK = 2'd1,
    SEL_THR   = 2'd2,
    SEL_RSVD  = 2'd3
  } msel_e;

  typedef enum logic [1:0] {
    CLS_NMI   = 2'd0,
    CLS_HARD  = 2'd1,
    CLS_OTHER = 2'd2
  } exc_cls_e;
endpackage

// File: rtl/mask_regs.sv
module mask_regs
  import exc_mask_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic              priv,
  input  logic [1:0]        rd_sel,
  output logic              gmask,
  output logic              fmask,
  output logic [PRIO_W-1:0] thr,
  output logic [PRIO_W-1:0] rd_data,
  output logic              acc_fault
);
  logic              gm_q, gm_d, fm_q, fm_d, fault_q, fault_d;
  logic [PRIO_W-1:0] thr_q, thr_d;
  logic              wr_ok;

  always_comb begin
    wr_ok   = wr_en && priv;
    fault_d = wr_en && !priv;
    gm_d    = gm_q;
    fm_d    = fm_q;
    thr_d   = thr_q;
    if (wr_ok) begin
      unique case (msel_e'(wr_sel))
        SEL_GMASK: gm_d  = wr_data[0];
        SEL_FMASK: fm_d  = wr_data[0];
        SEL_THR:   thr_d = wr_data;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gm_q    <= 1'b0;
      fm_q    <= 1'b0;
      thr_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      gm_q    <= gm_d;
      fm_q    <= fm_d;
      thr_q   <= thr_d;
      fault_q <= fault_d;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (msel_e'(rd_sel))
      SEL_GMASK: rd_data[0] = gm_q;
      SEL_FMASK: rd_data[0] = fm_q;
      SEL_THR:   rd_data    = thr_q;
      default:   rd_data    = '0;
    endcase
  end

  assign gmask     = gm_q;
  assign fmask     = fm_q;
  assign thr       = thr_q;
  assign acc_fault = fault_q;

  // R8: refused write leaves state alone and pulses the fault output
  a_r8_user_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !priv) |=> (acc_fault && $stable(gm_q) && $stable(fm_q) && $stable(thr_q)));
  // R8: the fault pulse lasts one cycle unless a new refused write arrives
  a_r8_fault_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !priv) |=> !acc_fault);
  // R7: privileged threshold write lands at the edge
  a_r7_thr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && priv && wr_sel == 2'd2) |=> (thr_q == $past(wr_data)));
  // R10: reserved select changes nothing
  a_r10_rsvd_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && priv && wr_sel == 2'd3) |=> ($stable(gm_q) && $stable(fm_q) && $stable(thr_q) && !acc_fault));
endmodule

// File: rtl/exc_classify.sv
module exc_classify
  import exc_mask_pkg::*;
#(
  parameter int unsigned TYPE_W = 9
) (
  input  logic [TYPE_W-1:0] exc_type,
  output exc_cls_e          cls
);
  always_comb begin
    if (exc_type == TYPE_W'(NMI_TYPE))       cls = CLS_NMI;
    else if (exc_type == TYPE_W'(HARD_TYPE)) cls = CLS_HARD;
    else                                     cls = CLS_OTHER;
  end
endmodule

// File: rtl/mask_gate.sv
module mask_gate
  import exc_mask_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  exc_cls_e          cls,
  input  logic [PRIO_W-1:0] prio,
  input  logic              gmask,
  input  logic              fmask,
  input  logic [PRIO_W-1:0] thr,
  output logic              allow
);
  logic thr_block;

  always_comb begin
    thr_block = (thr != '0) && (prio >= thr);
    unique case (cls)
      CLS_NMI:  allow = 1'b1;
      CLS_HARD: allow = !fmask;
      default:  allow = !fmask && !gmask && !thr_block;
    endcase
  end
endmodule

// File: rtl/exc_mask_filter.sv
module exc_mask_filter
  import exc_mask_pkg::*;
#(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned TYPE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_valid,
  input  logic [TYPE_W-1:0] pend_type,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              priv,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [PRIO_W-1:0] rd_data,
  output logic              take_ok,
  output logic              acc_fault
);
  logic              gmask, fmask, allow, ok_d, ok_q;
  logic [PRIO_W-1:0] thr;
  exc_cls_e          cls;

  mask_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .priv(priv), .rd_sel(rd_sel), .gmask(gmask), .fmask(fmask), .thr(thr),
    .rd_data(rd_data), .acc_fault(acc_fault)
  );

  exc_classify #(.TYPE_W(TYPE_W)) u_cls (.exc_type(pend_type), .cls(cls));

  mask_gate #(.PRIO_W(PRIO_W)) u_gate (
    .cls(cls), .prio(pend_prio), .gmask(gmask), .fmask(fmask), .thr(thr), .allow(allow)
  );

  always_comb ok_d = pend_valid && allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ok_d;
  end

  assign take_ok = ok_q;

  // R2: NMI always passes
  a_r2_nmi_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && pend_type == TYPE_W'(NMI_TYPE)) |=> take_ok);
  // R3: global mask blocks ordinary exceptions
  a_r3_gmask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask && pend_valid && pend_type != TYPE_W'(NMI_TYPE) && pend_type != TYPE_W'(HARD_TYPE)) |=> !take_ok);
  // R4: fault mask blocks everything but NMI
  a_r4_fmask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (fmask && pend_valid && pend_type != TYPE_W'(NMI_TYPE)) |=> !take_ok);
  // R5: inclusive threshold compare
  a_r5_thr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != '0 && pend_prio >= thr && pend_valid &&
     pend_type != TYPE_W'(NMI_TYPE) && pend_type != TYPE_W'(HARD_TYPE)) |=> !take_ok);
  // R9: nothing pending, nothing taken
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |=> !take_ok);
endmodule

// File: tb/sim_exc_mask_filter.sv
module sim_exc_mask_filter;
  localparam int PRIO_W = 8;
  localparam int TYPE_W = 9;
  localparam int NVEC   = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pend_valid = 1'b0, priv = 1'b1, wr_en = 1'b0;
  logic [TYPE_W-1:0] pend_type = '0;
  logic [PRIO_W-1:0] pend_prio = '0, wr_data = '0, rd_data;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic take_ok, acc_fault;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  exc_mask_filter #(.PRIO_W(PRIO_W), .TYPE_W(TYPE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pend_valid(pend_valid), .pend_type(pend_type),
    .pend_prio(pend_prio), .priv(priv), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .take_ok(take_ok),
    .acc_fault(acc_fault)
  );

  // {gmask, fmask, threshold, type, prio, expected take_ok}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h00, 9'd16, 8'h40, 1'b1},  // R6 open
    {1'b1, 1'b0, 8'h00, 9'd16, 8'h40, 1'b0},  // R3
    {1'b1, 1'b0, 8'h00, 9'd3,  8'h00, 1'b1},  // R3 hard fault exempt
    {1'b1, 1'b0, 8'h00, 9'd2,  8'h00, 1'b1},  // R2
    {1'b0, 1'b1, 8'h00, 9'd3,  8'h00, 1'b0},  // R4
    {1'b0, 1'b1, 8'h00, 9'd2,  8'h00, 1'b1},  // R2 under R4
    {1'b0, 1'b1, 8'h00, 9'd5,  8'h00, 1'b0},  // R4 system type
    {1'b0, 1'b0, 8'h40, 9'd16, 8'h40, 1'b0},  // R5 equal
    {1'b0, 1'b0, 8'h40, 9'd16, 8'h3F, 1'b1},  // R5 below
    {1'b0, 1'b0, 8'h40, 9'd16, 8'h80, 1'b0},  // R5 above
    {1'b0, 1'b0, 8'h40, 9'd3,  8'hFF, 1'b1},  // R5 hard fault ignores threshold
    {1'b0, 1'b0, 8'h40, 9'd6,  8'h41, 1'b0},  // R5 system type
    {1'b0, 1'b0, 8'h00, 9'd16, 8'hFF, 1'b1},  // R6 all-ones prio
    {1'b0, 1'b0, 8'h01, 9'd16, 8'h00, 1'b1}   // R5 zero prio under 1
  };

  task automatic check(input string req, input logic [PRIO_W-1:0] act, input logic [PRIO_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [1:0] sel, input logic [PRIO_W-1:0] d);
    @(negedge clk);
    priv = p; wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; priv = 1'b1;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [PRIO_W-1:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [PRIO_W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1 gmask", v, 8'h00);
    rd(2'd1, v); check("R1 fmask", v, 8'h00);
    rd(2'd2, v); check("R1 thr", v, 8'h00);
    check("R1 take_ok", {7'b0, take_ok}, 8'h00);
    check("R1 acc_fault", {7'b0, acc_fault}, 8'h00);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(1'b1, 2'd0, {7'b0, VEC[i][27]});
      wr(1'b1, 2'd1, {7'b0, VEC[i][26]});
      wr(1'b1, 2'd2, VEC[i][25:18]);
      rd(2'd2, v); check("R7 thr readback", v, VEC[i][25:18]);
      pend_valid = 1'b1; pend_type = VEC[i][17:9]; pend_prio = VEC[i][8:1];
      @(negedge clk);
      check($sformatf("R2-R6 vector %0d", i), {7'b0, take_ok}, {7'b0, VEC[i][0]});
      pend_valid = 1'b0;
      @(negedge clk);
      check("R9 idle", {7'b0, take_ok}, 8'h00);
    end

    // R8 user write refused
    wr(1'b1, 2'd0, 8'h00); wr(1'b1, 2'd1, 8'h00); wr(1'b1, 2'd2, 8'h00);
    @(negedge clk);
    priv = 1'b0; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h33;
    @(negedge clk);
    wr_en = 1'b0; priv = 1'b1;
    check("R8 fault pulse", {7'b0, acc_fault}, 8'h01);
    rd(2'd2, v); check("R8 thr unchanged", v, 8'h00);
    @(negedge clk);
    check("R8 pulse ends", {7'b0, acc_fault}, 8'h00);
    wr(1'b0, 2'd0, 8'h01);
    rd(2'd0, v); check("R8 gmask unchanged", v, 8'h00);

    // R7 mask bit reads only bit 0
    wr(1'b1, 2'd1, 8'hFF);
    rd(2'd1, v); check("R7 fmask read", v, 8'h01);
    wr(1'b1, 2'd1, 8'h00);

    // R10 reserved select
    wr(1'b1, 2'd3, 8'hFF);
    check("R10 no fault", {7'b0, acc_fault}, 8'h00);
    rd(2'd3, v); check("R10 read zero", v, 8'h00);
    rd(2'd0, v); check("R10 gmask intact", v, 8'h00);
    rd(2'd2, v); check("R10 thr intact", v, 8'h00);

    // R9 write and pending at the same edge: old mask decides
    @(negedge clk);
    pend_valid = 1'b1; pend_type = 9'd20; pend_prio = 8'h10;
    wr_en = 1'b1; priv = 1'b1; wr_sel = 2'd0; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 old mask used", {7'b0, take_ok}, 8'h01);
    @(negedge clk);
    check("R9 new mask used", {7'b0, take_ok}, 8'h00);
    pend_valid = 1'b0;

    // R1 reset mid-run clears state
    rst_n = 1'b0; #2;
    rd(2'd0, v); check("R1 reset clears gmask", v, 8'h00);
    check("R1 reset clears take_ok", {7'b0, take_ok}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule